// File: doc/BRIEF.md
# Clock Manager Reconfiguration Writer

This block reprograms an on-chip clock manager for one of seven serial line rates. On a start strobe it takes the clock manager into reset, loads eleven configuration registers through the manager's dynamic reconfiguration port, and releases the reset. It then waits a fixed settling interval and reports, with a one-cycle done pulse, whether the manager's lock output was high at the end of that interval. Every register value comes from an internal table. The table is keyed by the output divide and the feedback multiply that the selected rate needs.

When no sequence is running, a single register of the clock manager can also be read back through the same port. A read request that arrives while a sequence runs is dropped. All signals are on one clock, and that clock also drives the reconfiguration port.

Rate codes on `rate_sel` are 0: divide 32 / multiply 8, 1: divide 16 / multiply 8, 2: divide 16 / multiply 10, 3: divide 8 / multiply 8, 4: divide 8 / multiply 10, 5: divide 4 / multiply 8, and 6: divide 4 / multiply 10. Code 7 is not a rate.

Top module: `clkmgr_reconfig_writer`

## Requirements
- R1: `mgr_rst` goes high in the cycle after an accepted start, before the first port access. It stays high through the ready of the eleventh write and falls in the cycle after that ready.
- R2: One sequence makes exactly eleven writes, to addresses 0x08, 0x09, 0x14, 0x15, 0x16, 0x18, 0x19, 0x1A, 0x28, 0x4E, 0x4F in that order.
- R3: Every port access is a `drp_en` pulse of exactly one cycle. No new pulse is issued until `drp_rdy` has returned for the previous access.
- R4: On a write, `drp_we` is high in the same cycle as `drp_en`. On a read, `drp_en` is high with `drp_we` low. `drp_we` is never high without `drp_en`.
- R5: Address 0x08 receives 0x1410 for divide 32, 0x1208 for divide 16, 0x1104 for divide 8 and 0x1082 for divide 4.
- R6: For multiply 8 the values are 0x14=0x1104, 0x19=0x5801, 0x1A=0xDBE9, 0x4E=0x9808 and 0x4F=0x9100.
- R7: For multiply 10 the values are 0x14=0x1145, 0x19=0x7001, 0x1A=0xF3E9, 0x4E=0x9908 and 0x4F=0x1900.
- R8: For every rate, 0x09, 0x15 and 0x28 receive 0x0000, 0x16 receives 0x1041 and 0x18 receives 0x03E8.
- R9: `done` pulses for one cycle exactly SETTLE_CYCLES cycles after `mgr_rst` falls. From that pulse on, `locked_status` holds the value `mgr_locked` had in the last settling cycle.
- R10: When idle, `rd_req` starts a read of `rd_addr`. In the cycle after the read's `drp_rdy`, `rd_valid` pulses for one cycle and `rd_data` equals the `drp_rdata` value returned.
- R11: A `rd_req` or `start` that arrives while a sequence runs is ignored: no read access, no `rd_valid`, and the running sequence's writes are unchanged.
- R12: A `start` with `rate_sel` = 7 is ignored: no port access, no reset and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the reconfiguration port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Rate code, sampled with start |
| start | input | 1 | Begin a reconfiguration sequence |
| rd_req | input | 1 | Request a single register read |
| rd_addr | input | 7 | Register address for the read |
| rd_data | output | 16 | Data returned by the last read |
| rd_valid | output | 1 | One-cycle pulse, rd_data updated |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| locked_status | output | 1 | Lock value sampled at the end of settling |
| drp_addr | output | 7 | Port address |
| drp_wdata | output | 16 | Port write data |
| drp_en | output | 1 | Port access enable |
| drp_we | output | 1 | Port write enable |
| drp_rdy | input | 1 | Port access complete |
| drp_rdata | input | 16 | Port read data |
| mgr_rst | output | 1 | Reset to the clock manager |
| mgr_locked | input | 1 | Lock output of the clock manager |

## Verification
If the write index is corrupted, the writes go to addresses out of the fixed order, or the sequence has more or fewer than eleven writes. This shows at the port within one access of the fault. If the wait state is lost, a new enable appears before the ready arrives, which the bench model flags at once. If the settle counter or the reset register is wrong, the done pulse moves by whole cycles relative to the falling reset, and the bench measures that distance exactly. A wrong table entry shows as a wrong data word at the address concerned, so every rate is run and all eleven words are compared.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

  localparam int unsigned CMR_AW     = 7;
  localparam int unsigned CMR_DW     = 16;
  localparam int unsigned CMR_NREGS  = 11;
  localparam int unsigned CMR_IDX_W  = $clog2(CMR_NREGS);
  localparam logic [2:0]  CMR_RATE_NONE = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_SETTLE,
    ST_RD_REQ,
    ST_RD_WAIT
  } cmr_state_e;

  // Fixed programming order of the clock manager registers.
  function automatic logic [CMR_AW-1:0] cmr_reg_addr(input logic [CMR_IDX_W-1:0] idx);
    case (idx)
      4'd0:    return 7'h08;
      4'd1:    return 7'h09;
      4'd2:    return 7'h14;
      4'd3:    return 7'h15;
      4'd4:    return 7'h16;
      4'd5:    return 7'h18;
      4'd6:    return 7'h19;
      4'd7:    return 7'h1A;
      4'd8:    return 7'h28;
      4'd9:    return 7'h4E;
      4'd10:   return 7'h4F;
      default: return 7'h00;
    endcase
  endfunction

  // Feedback multiply of 10 for rate codes 2, 4, 6; otherwise 8.
  function automatic logic cmr_mul10(input logic [2:0] rate);
    return (rate == 3'd2) || (rate == 3'd4) || (rate == 3'd6);
  endfunction

  function automatic logic [CMR_DW-1:0] cmr_out_div_word(input logic [2:0] rate);
    case (rate)
      3'd0:       return 16'h1410;
      3'd1, 3'd2: return 16'h1208;
      3'd3, 3'd4: return 16'h1104;
      default:    return 16'h1082;
    endcase
  endfunction

  function automatic logic [CMR_DW-1:0] cmr_reg_value(input logic [2:0] rate,
                                                      input logic [CMR_IDX_W-1:0] idx);
    logic m10;
    m10 = cmr_mul10(rate);
    case (idx)
      4'd0:    return cmr_out_div_word(rate);
      4'd2:    return m10 ? 16'h1145 : 16'h1104;
      4'd4:    return 16'h1041;
      4'd5:    return 16'h03E8;
      4'd6:    return m10 ? 16'h7001 : 16'h5801;
      4'd7:    return m10 ? 16'hF3E9 : 16'hDBE9;
      4'd9:    return m10 ? 16'h9908 : 16'h9808;
      4'd10:   return m10 ? 16'h1900 : 16'h9100;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/cmr_value_table.sv
module cmr_value_table
  import cmr_pkg::*;
(
  input  logic [2:0]           rate,
  input  logic [CMR_IDX_W-1:0] idx,
  output logic [CMR_AW-1:0]    addr,
  output logic [CMR_DW-1:0]    data
);

  always_comb begin
    addr = cmr_reg_addr(idx);
    data = cmr_reg_value(rate, idx);
  end

endmodule

// File: rtl/cmr_drp_port.sv
module cmr_drp_port #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata_q,
  output logic          drp_en,
  output logic          drp_we,
  output logic [AW-1:0] drp_addr,
  output logic [DW-1:0] drp_wdata,
  input  logic          drp_rdy,
  input  logic [DW-1:0] drp_rdata
);

  logic          en_q, en_d;
  logic          we_q, we_d;
  logic          wait_q, wait_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          load;

  always_comb begin
    load   = req && !en_q && !wait_q;
    en_d   = load;
    we_d   = load && req_we;
    ack    = wait_q && drp_rdy;
    wait_d = wait_q;
    if (en_q)     wait_d = 1'b1;
    else if (ack) wait_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      we_q    <= 1'b0;
      wait_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      en_q   <= en_d;
      we_q   <= we_d;
      wait_q <= wait_d;
      if (load) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (ack) rdata_q <= drp_rdata;
    end
  end

  assign drp_en    = en_q;
  assign drp_we    = we_q;
  assign drp_addr  = addr_q;
  assign drp_wdata = wdata_q;

endmodule

// File: rtl/cmr_settle_timer.sv
module cmr_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = run && (cnt_q == CW'(SETTLE_CYCLES - 1));
    cnt_d  = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/clkmgr_reconfig_writer.sv
module clkmgr_reconfig_writer
  import cmr_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rate_sel,
  input  logic              start,
  input  logic              rd_req,
  input  logic [CMR_AW-1:0] rd_addr,
  output logic [CMR_DW-1:0] rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              locked_status,
  output logic [CMR_AW-1:0] drp_addr,
  output logic [CMR_DW-1:0] drp_wdata,
  output logic              drp_en,
  output logic              drp_we,
  input  logic              drp_rdy,
  input  logic [CMR_DW-1:0] drp_rdata,
  output logic              mgr_rst,
  input  logic              mgr_locked
);

  localparam logic [CMR_IDX_W-1:0] LAST_IDX = CMR_IDX_W'(CMR_NREGS - 1);

  cmr_state_e           state_q, state_d;
  logic [CMR_IDX_W-1:0] idx_q, idx_d;
  logic [2:0]           rate_q, rate_d;
  logic [CMR_AW-1:0]    rdaddr_q, rdaddr_d;
  logic                 rst_q, rst_d;
  logic                 done_q, done_d;
  logic                 lock_q, lock_d;
  logic                 rdv_q, rdv_d;

  logic                 port_req, port_we, port_ack;
  logic [CMR_AW-1:0]    port_addr, tbl_addr;
  logic [CMR_DW-1:0]    tbl_data;
  logic                 timer_run, timer_expire;

  cmr_value_table u_table (
    .rate (rate_q),
    .idx  (idx_q),
    .addr (tbl_addr),
    .data (tbl_data)
  );

  cmr_drp_port #(.AW(CMR_AW), .DW(CMR_DW)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (port_req),
    .req_we    (port_we),
    .req_addr  (port_addr),
    .req_wdata (tbl_data),
    .ack       (port_ack),
    .rdata_q   (rd_data),
    .drp_en    (drp_en),
    .drp_we    (drp_we),
    .drp_addr  (drp_addr),
    .drp_wdata (drp_wdata),
    .drp_rdy   (drp_rdy),
    .drp_rdata (drp_rdata)
  );

  cmr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .expire (timer_expire)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    rate_d    = rate_q;
    rdaddr_d  = rdaddr_q;
    rst_d     = rst_q;
    done_d    = 1'b0;
    lock_d    = lock_q;
    rdv_d     = 1'b0;
    port_req  = 1'b0;
    port_we   = 1'b0;
    port_addr = tbl_addr;
    timer_run = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start && (rate_sel != CMR_RATE_NONE)) begin
          rate_d  = rate_sel;
          idx_d   = '0;
          rst_d   = 1'b1;
          state_d = ST_WR_REQ;
        end else if (rd_req) begin
          rdaddr_d = rd_addr;
          state_d  = ST_RD_REQ;
        end
      end
      ST_WR_REQ: begin
        port_req = 1'b1;
        port_we  = 1'b1;
        state_d  = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (port_ack) begin
          if (idx_q == LAST_IDX) begin
            rst_d   = 1'b0;
            state_d = ST_SETTLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_WR_REQ;
          end
        end
      end
      ST_SETTLE: begin
        timer_run = 1'b1;
        if (timer_expire) begin
          done_d  = 1'b1;
          lock_d  = mgr_locked;
          state_d = ST_IDLE;
        end
      end
      ST_RD_REQ: begin
        port_req  = 1'b1;
        port_addr = rdaddr_q;
        state_d   = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (port_ack) begin
          rdv_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      rate_q   <= '0;
      rdaddr_q <= '0;
      rst_q    <= 1'b0;
      done_q   <= 1'b0;
      lock_q   <= 1'b0;
      rdv_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      rate_q   <= rate_d;
      rdaddr_q <= rdaddr_d;
      rst_q    <= rst_d;
      done_q   <= done_d;
      lock_q   <= lock_d;
      rdv_q    <= rdv_d;
    end
  end

  assign mgr_rst       = rst_q;
  assign done          = done_q;
  assign locked_status = lock_q;
  assign rd_valid      = rdv_q;

endmodule

// File: rtl/clkmgr_reconfig_writer_chk.sv
module clkmgr_reconfig_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic drp_en,
  input logic drp_we,
  input logic drp_rdy,
  input logic mgr_rst,
  input logic done,
  input logic rd_valid
);

  // R3: enable lasts one cycle
  a_r3_en_single: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en);

  // R4: write enable only together with enable
  a_r4_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    drp_we |-> drp_en);

  // R1: every write happens with the clock manager in reset
  a_r1_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (drp_en && drp_we) |-> mgr_rst);

  // R9: done is a single-cycle pulse and comes after reset release
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mgr_rst);

  // R11: no read access while a sequence holds the reset
  a_r11_no_read_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (drp_en && !drp_we) |-> !mgr_rst);

  // R10: read valid is a single-cycle pulse
  a_r10_rdv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R3: a ready never coincides with a fresh enable
  a_r3_rdy_not_with_en: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |-> !drp_rdy);

endmodule

bind clkmgr_reconfig_writer clkmgr_reconfig_writer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .drp_en   (drp_en),
  .drp_we   (drp_we),
  .drp_rdy  (drp_rdy),
  .mgr_rst  (mgr_rst),
  .done     (done),
  .rd_valid (rd_valid)
);

// File: tb/clkmgr_reconfig_writer_test.sv
module clkmgr_reconfig_writer_test;

  localparam int SETTLE = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rate_sel;
  logic        start, rd_req;
  logic [6:0]  rd_addr;
  logic [15:0] rd_data;
  logic        rd_valid, done, locked_status;
  logic [6:0]  drp_addr;
  logic [15:0] drp_wdata;
  logic        drp_en, drp_we;
  logic        drp_rdy;
  logic [15:0] drp_rdata;
  logic        mgr_rst, mgr_locked;

  int tests_run = 0;
  int tests_failed = 0;

  always #4 clk = ~clk;

  clkmgr_reconfig_writer #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .start(start),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .locked_status(locked_status),
    .drp_addr(drp_addr), .drp_wdata(drp_wdata), .drp_en(drp_en),
    .drp_we(drp_we), .drp_rdy(drp_rdy), .drp_rdata(drp_rdata),
    .mgr_rst(mgr_rst), .mgr_locked(mgr_locked)
  );

  // ---------------- clock manager model ----------------
  logic [15:0] mem [0:127];
  logic [6:0]  log_addr [0:31];
  logic [15:0] log_data [0:31];
  int          log_n, rd_acc, lat_cfg, lock_dly, lat_cnt, lock_cnt;
  logic        pending, log_clr, viol_overlap, viol_rst;
  logic [6:0]  pend_addr;
  logic        pend_we;

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'(i) ^ 16'hA5A5;
  end

  always @(posedge clk) begin
    drp_rdy <= 1'b0;
    if (log_clr) begin
      log_n <= 0; rd_acc <= 0; viol_overlap <= 1'b0; viol_rst <= 1'b0;
    end
    if (drp_en) begin
      if (pending) viol_overlap <= 1'b1;
      pending   <= 1'b1;
      lat_cnt   <= lat_cfg;
      pend_addr <= drp_addr;
      pend_we   <= drp_we;
      if (drp_we) begin
        if (!mgr_rst) viol_rst <= 1'b1;
        mem[drp_addr] <= drp_wdata;
        if (log_n < 32) begin
          log_addr[log_n] <= drp_addr;
          log_data[log_n] <= drp_wdata;
        end
        log_n <= log_n + 1;
      end else begin
        rd_acc <= rd_acc + 1;
      end
    end else if (pending) begin
      if (lat_cnt == 0) begin
        drp_rdy   <= 1'b1;
        drp_rdata <= mem[pend_addr];
        pending   <= 1'b0;
        if (pend_we && !mgr_rst) viol_rst <= 1'b1;
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end
    if (mgr_rst) begin
      mgr_locked <= 1'b0; lock_cnt <= 0;
    end else if (lock_cnt < lock_dly) begin
      lock_cnt <= lock_cnt + 1;
    end else begin
      mgr_locked <= 1'b1;
    end
  end

  // ---------------- expected values from the requirements ----------------
  function automatic logic [6:0] exp_addr(input int i);
    logic [6:0] t [0:10];
    t = '{7'h08, 7'h09, 7'h14, 7'h15, 7'h16, 7'h18, 7'h19, 7'h1A, 7'h28, 7'h4E, 7'h4F};
    return t[i];
  endfunction

  function automatic logic [15:0] exp_data(input int rate, input int i);
    bit m10 = (rate == 2 || rate == 4 || rate == 6);
    logic [15:0] d0;
    case (rate)
      0: d0 = 16'h1410;
      1, 2: d0 = 16'h1208;
      3, 4: d0 = 16'h1104;
      default: d0 = 16'h1082;
    endcase
    case (i)
      0: return d0;
      2: return m10 ? 16'h1145 : 16'h1104;
      4: return 16'h1041;
      5: return 16'h03E8;
      6: return m10 ? 16'h7001 : 16'h5801;
      7: return m10 ? 16'hF3E9 : 16'hDBE9;
      9: return m10 ? 16'h9908 : 16'h9808;
      10: return m10 ? 16'h1900 : 16'h9100;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  // One full reconfiguration; optional injection of a read and a second start.
  task automatic run_write(input int rate, input int lat, input int ldly,
                           input bit exp_lock, input bit inject);
    int  cyc = 0, settle_n = 0, rdv_seen = 0;
    bit  saw_rst = 0;
    lat_cfg = lat; lock_dly = ldly;
    clear_log();
    rate_sel = 3'(rate); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(mgr_rst == 1'b1 && log_n == 0, "R1 reset before first write", int'(mgr_rst), 1);
    while (!done && cyc < 3000) begin
      if (mgr_rst) saw_rst = 1;
      if (saw_rst && !mgr_rst) settle_n++;
      if (rd_valid) rdv_seen++;
      if (inject && cyc == 9) begin
        rd_req = 1'b1; rd_addr = 7'h4E; start = 1'b1; rate_sel = 3'(6 - rate);
      end else begin
        rd_req = 1'b0; start = 1'b0; rate_sel = 3'(rate);
      end
      @(negedge clk); cyc++;
    end
    rd_req = 1'b0; start = 1'b0;
    check(done == 1'b1, "R9 done reached", int'(done), 1);
    check(settle_n == SETTLE, "R9 settle interval", settle_n, SETTLE);
    check(locked_status == exp_lock, "R9 locked status", int'(locked_status), int'(exp_lock));
    check(!mgr_rst, "R1 reset released", int'(mgr_rst), 0);
    check(!viol_rst, "R1 writes inside reset", int'(viol_rst), 0);
    check(!viol_overlap, "R3 access waits for ready", int'(viol_overlap), 0);
    check(log_n == 11, "R2 write count", log_n, 11);
    for (int i = 0; i < 11; i++) begin
      check(log_addr[i] == exp_addr(i), "R2 write order", int'(log_addr[i]), int'(exp_addr(i)));
      check(log_data[i] == exp_data(rate, i),
            (i == 0) ? "R5 divide word" :
            (i == 1 || i == 3 || i == 4 || i == 5 || i == 8) ? "R8 common word" :
            (rate == 2 || rate == 4 || rate == 6) ? "R7 multiply 10 word" : "R6 multiply 8 word",
            int'(log_data[i]), int'(exp_data(rate, i)));
    end
    @(negedge clk);
    check(!done, "R9 done one cycle", int'(done), 0);
    if (inject) begin
      check(rd_acc == 0, "R11 read refused", rd_acc, 0);
      check(rdv_seen == 0 && !rd_valid, "R11 no read valid", rdv_seen, 0);
    end
    repeat (4) @(negedge clk);
    check(log_n == 11, "R11 no second sequence", log_n, 11);
  endtask

  task automatic run_read(input logic [6:0] a, input int lat, input logic [15:0] exp);
    int cyc = 0;
    lat_cfg = lat;
    clear_log();
    rd_addr = a; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    while (!rd_valid && cyc < 200) begin @(negedge clk); cyc++; end
    check(rd_valid == 1'b1, "R10 read valid", int'(rd_valid), 1);
    check(rd_data == exp, "R10 read data", int'(rd_data), int'(exp));
    check(rd_acc == 1 && log_n == 0, "R4 read is enable without write", rd_acc, 1);
    @(negedge clk);
    check(!rd_valid, "R10 valid one cycle", int'(rd_valid), 0);
  endtask

  task automatic run_invalid();
    clear_log();
    rate_sel = 3'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (done || mgr_rst || drp_en) check(0, "R12 code 7 ignored", 1, 0);
      @(negedge clk);
    end
    check(log_n == 0 && rd_acc == 0, "R12 no port access", log_n + rd_acc, 0);
  endtask

  initial begin
    #(8 * 150000);
    tests_failed++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_req = 1'b0; rd_addr = '0; rate_sel = '0;
    log_clr = 1'b1; lat_cfg = 0; lock_dly = 5; pending = 1'b0; drp_rdata = '0;
    repeat (5) @(negedge clk);
    check(!done && !drp_en && !mgr_rst && !rd_valid, "R1 reset state",
          {done, drp_en, mgr_rst, rd_valid}, 0);
    rst_n = 1'b1; log_clr = 1'b0;
    @(negedge clk);
    for (int r = 0; r < 7; r++) run_write(r, r % 3, 5, 1'b1, 1'b0);
    run_write(4, 2, 60, 1'b0, 1'b0);
    run_write(1, 1, 5, 1'b1, 1'b1);
    run_read(7'h4E, 0, 16'h9808);
    run_read(7'h30, 3, 16'h0030 ^ 16'hA5A5);
    run_invalid();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule